// File: doc/BRIEF.md
# Clock-Sampled Pin-Interface Byte SRAM

This block models a byte-wide static memory whose pins behave like an asynchronous SRAM. It has an address bus, a data bus split into input, output and output-enable, and three active-low controls: chip select, output enable and write strobe. One fast clock samples every pin. All control edges are found from the registered copies of the pins, so the pins may change at any time relative to the clock.

A single power-good input stands in for all supply supervision. While it is low, the memory is deselected. A write that loses power part way through is dropped and leaves the whole array untouched.

The depth is `2**ADDR_W` bytes. The full-size configuration, `ADDR_W = 15`, holds 32768 bytes. The default is kept smaller so that the block elaborates quickly. Pins pass through `SYNC_STAGES` (default 2) flip-flops. A pin level that is settled before rising edge k shows on the outputs after rising edge k+2.

Top module: `bytewide_sram_pins`

## Requirements
- R1: The array stores one DATA_W-bit byte at each of `2**ADDR_W` addresses, from address 0 to the highest address. Each location keeps its own value, independently of the others. `ADDR_W = 15` gives 32768 bytes.
- R2: When power is good, chip select is low, the write strobe is high and output enable is low, the block does two things: it drives `dq_oe` high, and it puts on `dq_out` the byte stored at `addr`. A pin level sampled at edge k reaches the outputs after edge k+2.
- R3: When output enable is high, `dq_oe` stays low, even while the other controls select a read.
- R4: A write opens when the later of the chip-select and write-strobe falls arrives. It closes at the earlier of their rises. The byte is committed when the write closes. It uses the `addr` and `dq_in` sampled on the last clock edge at which both controls were low. Data present earlier in the write has no effect.
- R5: While the write strobe is low, `dq_oe` stays low, even with output enable low. This includes the case where chip select and write strobe fall together.
- R6: While chip select is high, `dq_oe` stays low and pulses on the write strobe change no location.
- R7: While power-good is low, `dq_oe` stays low and no location is written.
- R8: When power-good drops during an open write, that write commits nothing and every location keeps its value. If power returns while both controls are still low, no write opens. A fresh falling edge is needed to open one.
- R9: Whenever `dq_oe` is low, `dq_out` is all zeros.
- R10: During reset and on leaving it, `dq_oe` is low and `dq_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_ok | input | 1 | Supply good; low deselects the memory |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data bus, inward half |
| dq_out | output | DATA_W | Data bus, outward half (zero when idle) |
| dq_oe | output | 1 | High when the data bus is driven |

## Verification
Writes are tried in three forms, each with its own end condition:
- strobe-bounded, ending on the write-strobe rise;
- select-bounded, ending on the chip-select rise;
- both controls falling and rising on the same edge.

These forms separate "commit on the first rise" from "commit on a particular pin". Every strobe-bounded write first shows wrong data and changes to the right data only before the end. This exposes any design that captures at the start of the write.

Power is removed in three situations: while idle, during a read and in the middle of an open write. The mid-write drop is followed by power returning with both controls still low. This separates a design that merely masks the commit from one that wrongly reopens the write.

Neighbouring addresses and both ends of the address range are read back to show that no location other than the addressed one changes.

// File: rtl/sram_pin_pkg.sv
// Shared types for the clock-sampled pin SRAM.
package sram_pin_pkg;

    // Decoded state of the control pins after synchronisation.
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,   // power not good: deselected
        MODE_IDLE  = 2'd1,   // chip select high
        MODE_READ  = 2'd2,   // selected, write strobe high
        MODE_WRITE = 2'd3    // selected, write strobe low
    } bus_mode_e;

endpackage

// File: rtl/pin_sync.sv
// pin_sync: a chain of STAGES flip-flops that carries a WIDTH-bit group of
// asynchronous pins into the clock domain.
// Assumes: the group is used as one sample; no multi-bit coherence is
// promised for bits that change within one clock.
module pin_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the pin sample one stage per clock; load the idle value in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            for (int s = STAGES - 1; s > 0; s--) chain[s] <= chain[s-1];
            chain[0] <= d;
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ctrl_decode.sv
// ctrl_decode: turns the synchronised control pins into a bus mode, an
// output-drive flag and a one-cycle write-commit strobe.
// Assumes: all inputs come from pin_sync; a write is opened only by a fresh
// entry into "both controls low" while power is good, and is dropped when
// power goes away.
module ctrl_decode
    import sram_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_s,
    input  logic we_n_s,
    input  logic oe_n_s,
    input  logic pwr_s,
    output logic drive_next,
    output logic drive_q,
    output logic commit
);

    bus_mode_e mode;
    logic      both_low;
    logic      both_low_q;
    logic      armed_q;
    logic      open_write;

    // Decode the present mode from the synchronised pins.
    always_comb begin
        if (!pwr_s)       mode = MODE_OFF;
        else if (ce_n_s)  mode = MODE_IDLE;
        else if (we_n_s)  mode = MODE_READ;
        else              mode = MODE_WRITE;
    end

    assign both_low   = !ce_n_s && !we_n_s;
    assign open_write = pwr_s && both_low && !both_low_q;
    assign drive_next = (mode == MODE_READ) && !oe_n_s;
    assign commit     = armed_q && pwr_s && !both_low;

    // Remember the previous both-low level to find the opening edge.
    always_ff @(posedge clk) begin
        if (!rst_n) both_low_q <= 1'b0;
        else        both_low_q <= both_low;
    end

    // Track whether a powered write is open.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b0;
        else if (!pwr_s)     armed_q <= 1'b0;
        else if (open_write) armed_q <= 1'b1;
        else if (!both_low)  armed_q <= 1'b0;
    end

    // Register the output-drive flag alongside the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= drive_next;
    end

endmodule

// File: rtl/byte_array.sv
// byte_array: DEPTH x DATA_W storage with one write port and one registered
// read port that returns zero when not enabled.
// Assumes: contents are not reset; a read and a write at the same edge to the
// same address return the old byte.
module byte_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the committed byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the read byte, or zero when the bus is not driven.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
        else            rd_data <= '0;
    end

endmodule

// File: rtl/bytewide_sram_pins.sv
// bytewide_sram_pins: byte SRAM with an asynchronous-style pin interface,
// sampled by a fast clock. Controls, address and data all pass through the
// same synchroniser depth so that they stay aligned. A write commits the byte
// sampled on the last cycle with both controls low.
// Assumes: the pins are held for at least one clock around each edge, and
// power-good is the only supply information.
module bytewide_sram_pins
    import sram_pin_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int CTRL_W = 4;
    localparam int BUS_W  = ADDR_W + DATA_W;

    logic [CTRL_W-1:0] ctrl_s;
    logic [BUS_W-1:0]  bus_s;
    logic [BUS_W-1:0]  bus_hold;
    logic              drive_next;
    logic              wr_commit;

    // Controls idle as deselected and unpowered during reset.
    pin_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_ctrl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n, pwr_ok}),
        .q     (ctrl_s)
    );

    pin_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, dq_in}),
        .q     (bus_s)
    );

    // Keep the previous address/data sample: the one in force while both
    // controls were still low when the closing edge is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_hold <= '0;
        else        bus_hold <= bus_s;
    end

    ctrl_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_s     (ctrl_s[3]),
        .we_n_s     (ctrl_s[2]),
        .oe_n_s     (ctrl_s[1]),
        .pwr_s      (ctrl_s[0]),
        .drive_next (drive_next),
        .drive_q    (dq_oe),
        .commit     (wr_commit)
    );

    byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_commit),
        .wr_addr (bus_hold[BUS_W-1:DATA_W]),
        .wr_data (bus_hold[DATA_W-1:0]),
        .rd_en   (drive_next),
        .rd_addr (bus_s[BUS_W-1:DATA_W]),
        .rd_data (dq_out)
    );

endmodule

// File: rtl/sram_pins_checker.sv
// sram_pins_checker: timing properties of the pin SRAM, seen from its ports
// plus the commit strobe. The pin-to-output latency is three sampled cycles
// with the default synchroniser depth.
module sram_pins_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              wr_commit
);

    logic [1:0] warm;

    // Count edges since reset so that $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 3)  warm <= warm + 2'd1;
    end

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3 && $past(pwr_ok,3) && !$past(ce_n,3) && $past(we_n,3) && !$past(oe_n,3)) |-> dq_oe); // R2
    AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3 && $past(oe_n,3)) |-> !dq_oe); // R3
    AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (warm == 3 && !$past(ce_n,3) && !$past(we_n,3))); // R4
    AST_STROBE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3 && !$past(we_n,3)) |-> !dq_oe); // R5
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3 && $past(ce_n,3)) |-> !dq_oe); // R6
    AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3 && !$past(pwr_ok,3)) |-> !dq_oe); // R7
    AST_NO_COMMIT_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(pwr_ok,2)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0)); // R9

endmodule

bind bytewide_sram_pins sram_pins_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .wr_commit (wr_commit)
);

// File: tb/sim_bytewide_sram_pins.sv
`timescale 1ns/1ps
module sim_bytewide_sram_pins;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R10";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    bytewide_sram_pins #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ---------------- behavioural reference model ----------------
    logic          h_ce [4], h_we [4], h_oe [4], h_pw [4];
    logic [AW-1:0] h_ad [4];
    logic [DW-1:0] h_dt [4];
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_known [DEPTH];
    bit            m_open = 1'b0;
    bit            e_oe = 1'b0;
    bit            e_known = 1'b1;
    logic [DW-1:0] e_out = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                h_ce[i] = 1'b1; h_we[i] = 1'b1; h_oe[i] = 1'b1; h_pw[i] = 1'b0;
                h_ad[i] = '0;   h_dt[i] = '0;
            end
            m_open = 1'b0; e_oe = 1'b0; e_out = '0; e_known = 1'b1;
        end else begin
            bit bl2, bl3, drv, cm;
            for (int i = 3; i > 0; i--) begin
                h_ce[i] = h_ce[i-1]; h_we[i] = h_we[i-1]; h_oe[i] = h_oe[i-1];
                h_pw[i] = h_pw[i-1]; h_ad[i] = h_ad[i-1]; h_dt[i] = h_dt[i-1];
            end
            h_ce[0] = ce_n; h_we[0] = we_n; h_oe[0] = oe_n; h_pw[0] = pwr_ok;
            h_ad[0] = addr; h_dt[0] = dq_in;
            bl2 = !h_ce[2] && !h_we[2];
            bl3 = !h_ce[3] && !h_we[3];
            drv = h_pw[2] && !h_ce[2] && h_we[2] && !h_oe[2];
            cm  = m_open && h_pw[2] && !bl2;
            e_oe = drv;
            if (drv) begin
                e_known = m_known[h_ad[2]];
                e_out   = m_mem[h_ad[2]];
            end else begin
                e_known = 1'b1;
                e_out   = '0;
            end
            if (cm) begin
                m_mem[h_ad[3]]   = h_dt[3];
                m_known[h_ad[3]] = 1'b1;
            end
            if (!h_pw[2])        m_open = 1'b0;
            else if (bl2 && !bl3) m_open = 1'b1;
            else if (!bl2)       m_open = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare the outputs against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(dq_oe === e_oe, phase, int'(dq_oe), int'(e_oe));
            if (e_known) chk(dq_out === e_out, phase, int'(dq_out), int'(e_out));
        end
    end

    // ---------------- stimulus helpers (drive on falling edge) ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_strobe(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; dq_in = ~d; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        cyc(1); we_n = 1'b0;
        cyc(2); dq_in = d;
        cyc(2); we_n = 1'b1;
        cyc(1); ce_n = 1'b1; dq_in = 8'h5A;
        cyc(3);
    endtask

    task automatic wr_select(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; dq_in = d; we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        cyc(1); ce_n = 1'b0;
        cyc(3); ce_n = 1'b1;
        cyc(1); we_n = 1'b1; dq_in = 8'hC3;
        cyc(3);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        cyc(4);
        chk(dq_oe === 1'b1, req, int'(dq_oe), 1);
        chk(dq_out === exp, req, int'(dq_out), int'(exp));
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(3);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        phase = "R10";
        pwr_ok = 1'b1;
        cyc(3);
        chk(dq_oe === 1'b0, "R10", int'(dq_oe), 0);
        chk(dq_out === '0, "R10", int'(dq_out), 0);
        rst_n = 1'b1;
        cyc(3);
        chk(dq_oe === 1'b0, "R10", int'(dq_oe), 0);

        phase = "R4";
        wr_strobe(11'd5, 8'hA5);
        rd_check(11'd5, 8'hA5, "R4");
        wr_select(11'd6, 8'h3E);
        rd_check(11'd6, 8'h3E, "R4");

        phase = "R1";
        wr_strobe(11'd0, 8'h01);
        wr_strobe(11'(DEPTH-1), 8'hFE);
        rd_check(11'd0, 8'h01, "R1");
        rd_check(11'(DEPTH-1), 8'hFE, "R1");
        rd_check(11'd5, 8'hA5, "R1");

        phase = "R2";
        rd_check(11'd6, 8'h3E, "R2");

        phase = "R3";
        addr = 11'd5; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        cyc(4);
        chk(dq_oe === 1'b0, "R3", int'(dq_oe), 0);
        chk(dq_out === '0, "R9", int'(dq_out), 0);
        ce_n = 1'b1; cyc(3);

        phase = "R5";
        addr = 11'd9; dq_in = 8'h77; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        cyc(4);
        chk(dq_oe === 1'b0, "R5", int'(dq_oe), 0);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(3);
        rd_check(11'd9, 8'h77, "R5");
        addr = 11'd9; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        cyc(4);
        dq_in = 8'h78; we_n = 1'b0;
        cyc(4);
        chk(dq_oe === 1'b0, "R5", int'(dq_oe), 0);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        cyc(3);
        rd_check(11'd9, 8'h78, "R5");

        phase = "R6";
        addr = 11'd5; dq_in = 8'h00; ce_n = 1'b1; oe_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            we_n = 1'b0; cyc(3); we_n = 1'b1; cyc(2);
        end
        chk(dq_oe === 1'b0, "R6", int'(dq_oe), 0);
        oe_n = 1'b1; cyc(3);
        rd_check(11'd5, 8'hA5, "R6");

        phase = "R7";
        pwr_ok = 1'b0;
        addr = 11'd6; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        cyc(4);
        chk(dq_oe === 1'b0, "R7", int'(dq_oe), 0);
        ce_n = 1'b1; oe_n = 1'b1; cyc(2);
        wr_strobe(11'd6, 8'hFF);
        pwr_ok = 1'b1; cyc(3);
        rd_check(11'd6, 8'h3E, "R7");

        phase = "R8";
        wr_strobe(11'd7, 8'h11);
        wr_strobe(11'd8, 8'h22);
        addr = 11'd7; dq_in = 8'h3C; ce_n = 1'b0; we_n = 1'b0;
        cyc(3); pwr_ok = 1'b0;
        cyc(4); pwr_ok = 1'b1;
        cyc(4); ce_n = 1'b1; we_n = 1'b1;
        cyc(3);
        rd_check(11'd7, 8'h11, "R8");
        rd_check(11'd8, 8'h22, "R8");
        wr_strobe(11'd7, 8'h3C);
        rd_check(11'd7, 8'h3C, "R8");

        phase = "R9";
        cyc(4);
        chk(dq_out === '0, "R9", int'(dq_out), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog(all) actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule